// File: doc/BRIEF.md
# Clocked Charge-Balance Frequency Converter

This block is a fully digital model of a charge-balance voltage-to-frequency converter whose reset interval is timed by an external conversion clock. An unsigned input code plays the part of the analog input level. A signed accumulator plays the part of the integrator. On every conversion-clock period the accumulator moves in the integrating (negative) direction by the input code. When it drops below zero the comparator trips and the control logic arms. It then waits for a falling edge and the following rising edge of the conversion clock. From that rising edge it applies a fixed reset charge of twice full scale for exactly one conversion-clock period, and it holds the active-low output pulse for that period.

The conversion clock is asynchronous to the system clock. It is brought in through a synchronizer and an edge detector, and every state change happens on a system-clock edge. Because a pulse is at least one full period long and needs a new falling-then-rising edge pair before it can start, the output rate is bounded by half the conversion-clock rate. Input codes above full scale therefore saturate the rate. In that case the accumulator clamps at a floor instead of wrapping and an overrange flag is raised. An optional stretcher lengthens each pulse to a programmable number of system cycles.

Top module: `clocked_vfc`

## Requirements
- R1: While reset is asserted and right after it is released, `pulse_n_o` is high, `overrange_o` is low and the accumulator holds zero.
- R2: On each conversion-clock rising edge the accumulator is reduced by `level_i`, and it is raised by 2×FULL_SCALE on the rising edge that ends a reset period. The average pulse count over N conversion periods is therefore N×`level_i`/(2×FULL_SCALE), within a small bounded error.
- R3: After the comparator trips, a reset period starts only on a conversion-clock rising edge that follows a falling edge seen after arming. `pulse_n_o` falls exactly SYNC_STAGES+1 system cycles after `conv_clk_i` rises (3 cycles with the defaults).
- R4: With the stretcher shorter than a conversion period, each low pulse lasts exactly one conversion-clock period, counted in system cycles from rising edge to rising edge.
- R5: `level_i` = 0 produces no pulses. `level_i` = FULL_SCALE produces one pulse every two conversion periods.
- R6: For `level_i` above FULL_SCALE the rate stays at half the conversion rate, the accumulator never goes below −4×FULL_SCALE (it clamps there), and `overrange_o` goes high on the edge where the clamp is reached.
- R7: When `level_i` returns within range, the accumulator recovers through the normal reset charges. `overrange_o` drops once the accumulator is non-negative again, and the rate returns to the transfer value.
- R8: With the stretcher enabled, the low pulse lasts max(conversion period, `stretch_len_i`) system cycles. A new reset period cannot start while the stretch count is still running; it is deferred to a later rising edge.
- R9: A `stretch_len_i` smaller than the conversion period (including 0) leaves the pulse width at exactly one conversion period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| conv_clk_i | input | 1 | External conversion clock, asynchronous, slower than `clk` |
| level_i | input | IN_W | Unsigned input code standing for the analog level; FULL_SCALE is nominal full scale |
| stretch_len_i | input | CNT_W | Minimum low time of the output pulse in system cycles |
| pulse_n_o | output | 1 | Active-low output pulse stream |
| overrange_o | output | 1 | High once the accumulator has clamped at its floor; cleared when it is non-negative again |

## Verification
The bench checks every output pulse against the conversion clock it sampled. A design that skipped the falling-edge wait, or that used an extra or missing register stage, would show a latency other than three cycles, or pulses more frequent than every second period. Pulse counts are compared over long windows at zero, quarter, full and above-full input. A design that wrapped the accumulator instead of clamping would produce bursts of extra pulses or a missing overrange flag. A design with a wrong reset charge would miss the transfer count. The recovery step back to an in-range input and a stretch longer than two conversion periods catch a flag that sticks and a stretcher that lets a new pulse start early or merges pulses.

// File: rtl/cvfc_pkg.sv
package cvfc_pkg;

  typedef enum logic [1:0] {
    S_IDLE      = 2'd0,
    S_WAIT_FALL = 2'd1,
    S_WAIT_RISE = 2'd2,
    S_RESET     = 2'd3
  } vfc_state_t;

endpackage

// File: rtl/cvfc_edge_sync.sv
module cvfc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic [SYNC_STAGES-1:0] chain_d;
  logic                   last_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb chain_d = async_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[SYNC_STAGES-2:0], async_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[SYNC_STAGES-1];
    end
  end

  assign rise_o =  chain_q[SYNC_STAGES-1] & ~last_q;
  assign fall_o = ~chain_q[SYNC_STAGES-1] &  last_q;

  // R3: a detected edge is one cycle wide
  a_r3_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/cvfc_integrator.sv
module cvfc_integrator #(
  parameter int IN_W       = 8,
  parameter int FULL_SCALE = 200,
  parameter int ACC_W      = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rise_i,
  input  logic            charge_i,
  input  logic [IN_W-1:0] level_i,
  output logic            trip_o,
  output logic            overrange_o
);

  localparam int REF_CHARGE = 2 * FULL_SCALE;
  localparam int FLOOR_MAG  = 4 * FULL_SCALE;
  localparam logic signed [ACC_W-1:0] REF_C   = ACC_W'(REF_CHARGE);
  localparam logic signed [ACC_W-1:0] FLOOR_C = ACC_W'(-FLOOR_MAG);

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [ACC_W-1:0] lvl_s;
  logic signed [ACC_W-1:0] sum;
  logic                    clamp;
  logic                    ovr_q, ovr_d;

  assign lvl_s = $signed({{(ACC_W-IN_W){1'b0}}, level_i});

  always_comb begin
    sum = acc_q - lvl_s;
    if (charge_i) begin
      sum = sum + REF_C;
    end
    clamp = (sum <= FLOOR_C);
    acc_d = acc_q;
    if (rise_i) begin
      acc_d = clamp ? FLOOR_C : sum;
    end
    ovr_d = ovr_q;
    if (rise_i && clamp) begin
      ovr_d = 1'b1;
    end else if (!acc_q[ACC_W-1]) begin
      ovr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (rise_i) begin
        acc_q <= acc_d;
      end
      ovr_q <= ovr_d;
    end
  end

  assign trip_o      = acc_q[ACC_W-1];
  assign overrange_o = ovr_q;

  // R2: the accumulator only moves on a conversion-clock rising edge
  a_r2_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_i |=> $stable(acc_q));

  // R6: never below the floor
  a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q >= FLOOR_C);

  // R6: sitting at the floor means the flag is up
  a_r6_flag_at_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == FLOOR_C) |-> overrange_o);

  // R7: flag is down whenever the accumulator is non-negative on a quiet cycle
  a_r7_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_q[ACC_W-1] && !rise_i) |=> !overrange_o);

endmodule

// File: rtl/cvfc_ctrl.sv
module cvfc_ctrl
  import cvfc_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter bit STRETCH_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             trip_i,
  input  logic [CNT_W-1:0] stretch_len_i,
  output logic             charge_o,
  output logic             pulse_n_o
);

  vfc_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start;
  logic             stretch_idle;
  logic             pulse_n_q, pulse_n_d;

  assign stretch_idle = (cnt_q == '0);
  assign start        = (st_q == S_WAIT_RISE) && rise_i && stretch_idle;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:      if (trip_i) st_d = S_WAIT_FALL;
      S_WAIT_FALL: if (fall_i) st_d = S_WAIT_RISE;
      S_WAIT_RISE: if (start)  st_d = S_RESET;
      S_RESET:     if (rise_i) st_d = S_IDLE;
      default:     st_d = S_IDLE;
    endcase
  end

  generate
    if (STRETCH_EN) begin : g_stretch
      always_comb begin
        if (start) begin
          cnt_d = stretch_len_i;
        end else if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else begin
          cnt_d = cnt_q;
        end
      end

      // R8: no reset period may begin while the stretch count runs
      a_r8_no_early_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_WAIT_RISE && cnt_q != '0) |=> (st_q != S_RESET));
    end else begin : g_plain
      always_comb cnt_d = '0;
    end
  endgenerate

  assign pulse_n_d = !((st_d == S_RESET) || (cnt_d != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      pulse_n_q <= 1'b1;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      pulse_n_q <= pulse_n_d;
    end
  end

  assign charge_o  = (st_q == S_RESET);
  assign pulse_n_o = pulse_n_q;

  // R3: every leading edge of the pulse follows a detected rising edge
  a_r3_fall_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_n_o) |-> $past(rise_i));

  // R4: a reset period is left only on a rising edge
  a_r4_full_period: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RESET && !rise_i) |=> (st_q == S_RESET));

  // R4: output is low throughout a reset period
  a_r4_low_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RESET) |-> !pulse_n_o);

endmodule

// File: rtl/clocked_vfc.sv
module clocked_vfc #(
  parameter int IN_W        = 8,
  parameter int FULL_SCALE  = 200,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit STRETCH_EN  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_clk_i,
  input  logic [IN_W-1:0]  level_i,
  input  logic [CNT_W-1:0] stretch_len_i,
  output logic             pulse_n_o,
  output logic             overrange_o
);

  localparam int SPAN  = 6 * FULL_SCALE + (1 << IN_W);
  localparam int ACC_W = $clog2(SPAN) + 2;

  logic rise, fall, trip, charge;

  cvfc_edge_sync #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (conv_clk_i),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  cvfc_integrator #(
    .IN_W       (IN_W),
    .FULL_SCALE (FULL_SCALE),
    .ACC_W      (ACC_W)
  ) u_integ (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_i      (rise),
    .charge_i    (charge),
    .level_i     (level_i),
    .trip_o      (trip),
    .overrange_o (overrange_o)
  );

  cvfc_ctrl #(
    .CNT_W      (CNT_W),
    .STRETCH_EN (STRETCH_EN)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .rise_i        (rise),
    .fall_i        (fall),
    .trip_i        (trip),
    .stretch_len_i (stretch_len_i),
    .charge_o      (charge),
    .pulse_n_o     (pulse_n_o)
  );

  // R1: quiet outputs in the first cycle after reset release
  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (pulse_n_o && !overrange_o));

endmodule

// File: tb/clocked_vfc_tb.sv
module clocked_vfc_tb;

  localparam int IN_W  = 8;
  localparam int FS    = 200;
  localparam int CNT_W = 8;
  localparam int CPER  = 8;
  localparam int LAT   = 3;
  localparam int WIN   = 80;

  typedef struct {
    int    exp_cnt;
    int    tol;
    int    exp_w;
    int    exp_ovr;
    string tag;
  } exp_t;

  logic             clk;
  logic             rst_n;
  logic             conv;
  logic [IN_W-1:0]  level;
  logic [CNT_W-1:0] slen;
  logic             pulse_n;
  logic             ovr;

  int   total, bad;
  int   win_cnt, wmin, wmax, lowrun, since;
  bit   prev_c, prev_p;
  bit   finished;
  exp_t q[$];

  clocked_vfc #(
    .IN_W (IN_W), .FULL_SCALE (FS), .CNT_W (CNT_W), .SYNC_STAGES (2), .STRETCH_EN (1'b1)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .conv_clk_i (conv), .level_i (level),
    .stretch_len_i (slen), .pulse_n_o (pulse_n), .overrange_o (ovr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // conversion clock: CPER system cycles, low half first
  initial begin
    int ph;
    ph   = 0;
    conv = 1'b0;
    forever begin
      @(posedge clk);
      #5;
      ph   = (ph + 1) % CPER;
      conv = (ph >= CPER / 2);
    end
  end

  // monitor: pulse count, widths and edge latency
  initial begin
    prev_c = 1'b0; prev_p = 1'b1; since = 0; lowrun = 0;
    win_cnt = 0; wmin = 1 << 20; wmax = 0;
    forever begin
      @(posedge clk);
      #12;
      if (rst_n) begin
        since = (conv && !prev_c) ? 0 : since + 1;
        if (!pulse_n && prev_p) begin
          win_cnt++;
          total++;
          if (since != LAT) begin
            bad++;
            $display("FAIL R3 latency from conversion edge: got %0d expected %0d", since, LAT);
          end
        end
        if (!pulse_n) lowrun++;
        if (pulse_n && !prev_p) begin
          if (lowrun < wmin) wmin = lowrun;
          if (lowrun > wmax) wmax = lowrun;
          lowrun = 0;
        end
        prev_c = conv;
        prev_p = pulse_n;
      end
    end
  end

  // scoreboard: pop expectations and compare with observations
  initial begin
    exp_t e;
    forever begin
      wait (q.size() > 0);
      e = q.pop_front();
      total++;
      if (win_cnt < e.exp_cnt - e.tol || win_cnt > e.exp_cnt + e.tol) begin
        bad++;
        $display("FAIL %s pulse count: got %0d expected %0d +-%0d", e.tag, win_cnt, e.exp_cnt, e.tol);
      end
      if (e.exp_w > 0) begin
        total++;
        if (wmin != e.exp_w || wmax != e.exp_w) begin
          bad++;
          $display("FAIL %s pulse width: got %0d..%0d expected %0d", e.tag, wmin, wmax, e.exp_w);
        end
      end
      if (e.exp_ovr >= 0) begin
        total++;
        if (int'(ovr) != e.exp_ovr) begin
          bad++;
          $display("FAIL %s overrange flag: got %0d expected %0d", e.tag, ovr, e.exp_ovr);
        end
      end
    end
  end

  task automatic run_case(input int lvl, input int sl, input int settle,
                          input int exp_cnt, input int tol, input int exp_w,
                          input int exp_ovr, input string tag);
    exp_t e;
    level = IN_W'(lvl);
    slen  = CNT_W'(sl);
    repeat (settle * CPER) @(posedge clk);
    #3;
    win_cnt = 0; wmin = 1 << 20; wmax = 0;
    repeat (WIN * CPER) @(posedge clk);
    #3;
    e.exp_cnt = exp_cnt; e.tol = tol; e.exp_w = exp_w; e.exp_ovr = exp_ovr; e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
    #1;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; finished = 1'b0;
    rst_n = 1'b0; level = '0; slen = '0;
    repeat (5) @(posedge clk);
    #3;
    total++;
    if (pulse_n !== 1'b1 || ovr !== 1'b0) begin
      bad++;
      $display("FAIL R1 in reset: got pulse_n=%0b ovr=%0b expected 1 0", pulse_n, ovr);
    end
    rst_n = 1'b1;
    @(posedge clk);
    #3;
    total++;
    if (pulse_n !== 1'b1 || ovr !== 1'b0) begin
      bad++;
      $display("FAIL R1 after release: got pulse_n=%0b ovr=%0b expected 1 0", pulse_n, ovr);
    end

    run_case(0,   0,  4, 0,      0, 0,    0,  "R5 zero input");
    run_case(100, 0,  8, WIN/4,  2, CPER, 0,  "R2 R4 quarter scale");
    run_case(200, 0,  8, WIN/2,  1, CPER, 0,  "R5 full scale");
    run_case(255, 0, 40, WIN/2,  1, CPER, 1,  "R6 overrange");
    run_case(100, 0, 40, WIN/4,  2, CPER, 0,  "R7 recovery");
    run_case(50,  20, 8, WIN/8,  2, 20,   -1, "R8 stretched width");
    run_case(50,  5,  8, WIN/8,  2, CPER, -1, "R9 short stretch");
    run_case(200, 20, 8, WIN/3,  1, 20,   -1, "R8 deferred start");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule